// File: doc/BRIEF.md
# Unaligned Word Access Splitter

This block sits between a processor-side load/store port and a memory bus that is two bytes wide. A request carries a 20-bit byte address, a byte/word size flag and a read/write flag. An aligned word moves in a single bus cycle with both byte lanes enabled. A word at an odd address is broken into two single-byte bus cycles, and the block puts each byte on the lane that matches its address. On reads, the block joins the two bytes again in little-endian order.

A mode input selects a one-byte-wide bus instead. In that mode every transfer uses lane 0 only, and every word takes two transfers, whether or not its address is aligned. The request side uses a valid/ready handshake. The bus side holds each cycle until the memory acknowledges it, so a slow memory can stretch a cycle with wait states. All bus outputs come straight from registers.

Top module: `access_splitter`

## Requirements
- R1: While reset is high, and right after it is released, `bus_valid` and `req_ready` are both 0.
- R2: In 16-bit mode (`narrow_mode`=0), a word request at an even address makes exactly one bus cycle at that address with `bus_be`=2'b11. A read returns `bus_rdata` unchanged.
- R3: In 16-bit mode, a byte request makes exactly one bus cycle at its own address. `bus_be` is 2'b01 when bit 0 of the address is 0 and 2'b10 when it is 1. Read data comes from the matching lane and is returned zero-extended in `rsp_rdata[7:0]`.
- R4: In 16-bit mode, a word request at an odd address makes two bus cycles. The first is at the address with `bus_be`=2'b10, and the second is at the address plus one with `bus_be`=2'b01.
- R5: With `narrow_mode`=1, every bus cycle has `bus_be`=2'b01. A byte request takes one cycle and a word request takes two, at the address and then the address plus one, whatever the alignment.
- R6: The data of a split word is little-endian. The byte at the lower address is `rsp_rdata[7:0]` on reads and `req_wdata[7:0]` on writes, and it is transferred in the first cycle.
- R7: `req_ready` stays low until the last bus cycle of a request has been acknowledged. It is then high for exactly one clock, and `rsp_rdata` is valid in that clock.
- R8: Once `bus_valid` is high, `bus_addr`, `bus_be` and `bus_wdata` stay stable until a clock edge at which `bus_ack` is high.
- R9: The address of the second cycle is the request address plus one, modulo 2^20, so a word at 0xFFFFF continues at 0x00000.
- R10: On a single-byte write cycle, the byte being written is driven on both lanes, and `bus_be` selects the lane that the memory stores.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| narrow_mode | input | 1 | 1 selects the one-byte bus, 0 the two-byte bus; sampled when a request is accepted |
| req_valid | input | 1 | Request present; held until `req_ready` |
| req_write | input | 1 | 1 write, 0 read |
| req_word | input | 1 | 1 word, 0 byte |
| req_addr | input | 20 | Byte address |
| req_wdata | input | 16 | Write data; the low byte goes to the lower address |
| req_ready | output | 1 | One-clock completion pulse |
| rsp_rdata | output | 16 | Read data, valid with `req_ready` |
| bus_valid | output | 1 | Bus cycle request |
| bus_write | output | 1 | Bus cycle direction |
| bus_addr | output | 20 | Bus byte address |
| bus_be | output | 2 | Lane enables, active high; bit 0 is lane 0 (data bits 7:0) |
| bus_wdata | output | 16 | Write data on both lanes |
| bus_rdata | input | 16 | Read data from memory |
| bus_ack | input | 1 | Completes the current bus cycle |

## Verification
The bench builds the block with its default widths: a 20-bit address and 8-bit lanes. It sweeps both bus modes, both access sizes, reads and writes, and all eight alignments of the low address bits, plus the two addresses at the top of the address space. Against a byte-array memory, this reaches every lane selection, every split and unsplit path, and the address wrap. Half of the sweep runs with one wait state per bus cycle, which exercises how a cycle is held across a stall.

// File: rtl/splitter_pkg.sv
package splitter_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_BUS  = 2'd1,
    ST_DONE = 2'd2
  } seq_state_t;
endpackage

// File: rtl/splitter_steer.sv
// Computes lane enables and lane write data for one bus cycle.
module splitter_steer #(
  parameter int BYTE_W = 8
) (
  input  logic                narrow,
  input  logic                pair,
  input  logic                addr0,
  input  logic [BYTE_W-1:0]   wbyte,
  input  logic [2*BYTE_W-1:0] wword,
  output logic [1:0]          be,
  output logic [2*BYTE_W-1:0] wdata
);
  localparam int LANES = 2;

  for (genvar ln = 0; ln < LANES; ln++) begin : g_lane
    // a single byte is replicated; the enable picks the lane that stores it
    assign wdata[ln*BYTE_W +: BYTE_W] = pair ? wword[ln*BYTE_W +: BYTE_W] : wbyte;
  end

  always_comb begin
    if (pair)                 be = 2'b11;
    else if (narrow || !addr0) be = 2'b01;
    else                      be = 2'b10;
  end
endmodule

// File: rtl/splitter_extract.sv
// Picks the byte of the current bus cycle out of the lane data.
module splitter_extract #(
  parameter int BYTE_W = 8
) (
  input  logic                narrow,
  input  logic                addr0,
  input  logic [2*BYTE_W-1:0] rdata,
  output logic [BYTE_W-1:0]   rbyte
);
  assign rbyte = (!narrow && addr0) ? rdata[2*BYTE_W-1:BYTE_W] : rdata[BYTE_W-1:0];
endmodule

// File: rtl/access_splitter.sv
module access_splitter #(
  parameter int ADDR_W = 20,
  parameter int BYTE_W = 8
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                narrow_mode,
  input  logic                req_valid,
  input  logic                req_write,
  input  logic                req_word,
  input  logic [ADDR_W-1:0]   req_addr,
  input  logic [2*BYTE_W-1:0] req_wdata,
  output logic                req_ready,
  output logic [2*BYTE_W-1:0] rsp_rdata,
  output logic                bus_valid,
  output logic                bus_write,
  output logic [ADDR_W-1:0]   bus_addr,
  output logic [1:0]          bus_be,
  output logic [2*BYTE_W-1:0] bus_wdata,
  input  logic [2*BYTE_W-1:0] bus_rdata,
  input  logic                bus_ack
);
  import splitter_pkg::*;

  localparam int WORD_W = 2 * BYTE_W;

  seq_state_t          state_q;
  logic                phase_q, split_q, pair_q, narrow_q;
  logic [WORD_W-1:0]   wdata_q, rdata_q;
  logic [BYTE_W-1:0]   lo_q;
  logic                bv_q, bw_q;
  logic [ADDR_W-1:0]   ba_q;
  logic [1:0]          be_q;
  logic [WORD_W-1:0]   bd_q;

  // next bus cycle: either the first one of a new request or the second half of a split
  logic                idle;
  logic [ADDR_W-1:0]   iss_addr;
  logic                iss_narrow, iss_pair;
  logic [BYTE_W-1:0]   iss_wbyte;
  logic [1:0]          iss_be;
  logic [WORD_W-1:0]   iss_wdata;
  logic [BYTE_W-1:0]   ext_byte;

  assign idle       = (state_q == ST_IDLE);
  assign iss_addr   = idle ? req_addr : ba_q + ADDR_W'(1);
  assign iss_narrow = idle ? narrow_mode : narrow_q;
  assign iss_pair   = idle ? (req_word && !narrow_mode && !req_addr[0]) : 1'b0;
  assign iss_wbyte  = idle ? req_wdata[BYTE_W-1:0] : wdata_q[WORD_W-1:BYTE_W];

  splitter_steer #(.BYTE_W(BYTE_W)) u_steer (
    .narrow (iss_narrow),
    .pair   (iss_pair),
    .addr0  (iss_addr[0]),
    .wbyte  (iss_wbyte),
    .wword  (req_wdata),
    .be     (iss_be),
    .wdata  (iss_wdata)
  );

  splitter_extract #(.BYTE_W(BYTE_W)) u_extract (
    .narrow (narrow_q),
    .addr0  (ba_q[0]),
    .rdata  (bus_rdata),
    .rbyte  (ext_byte)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q  <= ST_IDLE;
      phase_q  <= 1'b0;
      split_q  <= 1'b0;
      pair_q   <= 1'b0;
      narrow_q <= 1'b0;
      wdata_q  <= '0;
      rdata_q  <= '0;
      lo_q     <= '0;
      bv_q     <= 1'b0;
      bw_q     <= 1'b0;
      ba_q     <= '0;
      be_q     <= '0;
      bd_q     <= '0;
    end else begin
      case (state_q)
        ST_IDLE: if (req_valid) begin
          wdata_q  <= req_wdata;
          narrow_q <= narrow_mode;
          pair_q   <= iss_pair;
          split_q  <= req_word && !iss_pair;
          phase_q  <= 1'b0;
          bv_q     <= 1'b1;
          bw_q     <= req_write;
          ba_q     <= iss_addr;
          be_q     <= iss_be;
          bd_q     <= iss_wdata;
          state_q  <= ST_BUS;
        end
        ST_BUS: if (bus_ack) begin
          if (split_q && !phase_q) begin
            phase_q <= 1'b1;
            lo_q    <= ext_byte;
            ba_q    <= iss_addr;
            be_q    <= iss_be;
            bd_q    <= iss_wdata;
          end else begin
            bv_q    <= 1'b0;
            state_q <= ST_DONE;
            if (pair_q)       rdata_q <= bus_rdata;
            else if (split_q) rdata_q <= {ext_byte, lo_q};
            else              rdata_q <= {{BYTE_W{1'b0}}, ext_byte};
          end
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign req_ready = (state_q == ST_DONE);
  assign rsp_rdata = rdata_q;
  assign bus_valid = bv_q;
  assign bus_write = bw_q;
  assign bus_addr  = ba_q;
  assign bus_be    = be_q;
  assign bus_wdata = bd_q;

  p_ready_pulse_r7: assert property (@(posedge clk) disable iff (rst)
    req_ready |=> !req_ready);

  p_ready_after_ack_r7: assert property (@(posedge clk) disable iff (rst)
    $rose(req_ready) |-> $past(bus_ack) && $past(bus_valid));

  p_hold_cycle_r8: assert property (@(posedge clk) disable iff (rst)
    bus_valid && !bus_ack |=> bus_valid && $stable(bus_addr) && $stable(bus_be) && $stable(bus_wdata));

  p_narrow_lane_r5: assert property (@(posedge clk) disable iff (rst)
    bus_valid && narrow_q |-> bus_be == 2'b01);

  p_odd_lane_r4: assert property (@(posedge clk) disable iff (rst)
    bus_valid && !narrow_q && bus_addr[0] |-> bus_be == 2'b10);

  p_second_addr_r9: assert property (@(posedge clk) disable iff (rst)
    bus_valid && bus_ack && split_q && !phase_q |=>
      bus_valid && bus_addr == ADDR_W'($past(bus_addr) + ADDR_W'(1)));
endmodule

// File: tb/access_splitter_test.sv
`timescale 1ns/1ps
module access_splitter_test;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        narrow_mode = 1'b0;
  logic        req_valid = 1'b0, req_write = 1'b0, req_word = 1'b0;
  logic [19:0] req_addr = '0;
  logic [15:0] req_wdata = '0;
  logic        req_ready;
  logic [15:0] rsp_rdata;
  logic        bus_valid, bus_write;
  logic [19:0] bus_addr;
  logic [1:0]  bus_be;
  logic [15:0] bus_wdata;
  logic [15:0] bus_rdata = '0;
  logic        bus_ack = 1'b0;

  int checks = 0, errors = 0;
  int wait_cfg = 0, wcnt = 0, xcnt = 0;
  logic [19:0] xa [0:3];
  logic [1:0]  xb [0:3];
  logic [7:0]  mem [0:255];
  logic [7:0]  shadow [0:255];

  always #2.5 clk = ~clk;

  access_splitter uut (
    .clk(clk), .rst(rst), .narrow_mode(narrow_mode),
    .req_valid(req_valid), .req_write(req_write), .req_word(req_word),
    .req_addr(req_addr), .req_wdata(req_wdata),
    .req_ready(req_ready), .rsp_rdata(rsp_rdata),
    .bus_valid(bus_valid), .bus_write(bus_write), .bus_addr(bus_addr),
    .bus_be(bus_be), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .bus_ack(bus_ack)
  );

  // behavioural byte memory with optional wait states
  always @(negedge clk) begin
    if (rst) begin
      bus_ack = 1'b0;
      wcnt = 0;
    end else if (bus_ack) begin
      bus_ack = 1'b0;
    end else if (bus_valid) begin
      if (wcnt < wait_cfg) wcnt++;
      else begin
        wcnt = 0;
        bus_ack = 1'b1;
        for (int l = 0; l < 2; l++) begin
          logic [7:0] idx;
          idx = narrow_mode ? bus_addr[7:0] : {bus_addr[7:1], l[0]};
          if (narrow_mode && l == 1) bus_rdata[15:8] = 8'hEE;
          else bus_rdata[l*8 +: 8] = mem[idx];
          if (bus_write && bus_be[l]) mem[idx] = bus_wdata[l*8 +: 8];
        end
        if (xcnt < 4) begin
          xa[xcnt] = bus_addr;
          xb[xcnt] = bus_be;
        end
        xcnt++;
      end
    end
  end

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic do_req(input bit wr, input bit wd, input logic [19:0] a,
                        input logic [15:0] wv, output logic [15:0] rv);
    int guard = 0;
    logic [1:0] exp_be;
    int exp_n;
    @(negedge clk);
    xcnt = 0;
    req_write = wr; req_word = wd; req_addr = a; req_wdata = wv; req_valid = 1'b1;
    do begin
      @(negedge clk);
      guard++;
    end while (!req_ready && guard < 200);
    chk(guard < 200, "R7 completion", guard, 200);
    rv = rsp_rdata;
    req_valid = 1'b0;
    exp_n = (wd && (narrow_mode || a[0])) ? 2 : 1;
    chk(xcnt == exp_n, narrow_mode ? "R5 transfer count" : (exp_n == 2 ? "R4 transfer count" : "R2/R3 count"),
        xcnt, exp_n);
    exp_be = narrow_mode ? 2'b01 : (wd && !a[0]) ? 2'b11 : (a[0] ? 2'b10 : 2'b01);
    chk(xa[0] == a && xb[0] == exp_be, "R3 first cycle addr/be", {xa[0], 2'b0, xb[0]}, {a, 2'b0, exp_be});
    if (exp_n == 2 && xcnt >= 2)
      chk(xa[1] == a + 20'd1 && xb[1] == 2'b01, "R9 second cycle addr/be",
          {xa[1], 2'b0, xb[1]}, {a + 20'd1, 4'b0001});
    @(negedge clk);
    chk(!req_ready, "R7 ready pulse length", req_ready, 0);
  endtask

  initial begin
    #(5.0 * 150000);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    logic [19:0] addrs [0:9];
    logic [15:0] rv, ev, wv;
    for (int i = 0; i < 256; i++) begin
      mem[i] = 8'(i * 7 + 3);
      shadow[i] = 8'(i * 7 + 3);
    end
    for (int i = 0; i < 8; i++) addrs[i] = 20'(i + 8);
    addrs[8] = 20'hFFFFE;
    addrs[9] = 20'hFFFFF;
    repeat (3) @(negedge clk);
    chk(!bus_valid && !req_ready, "R1 reset outputs", {bus_valid, req_ready}, 0);
    rst = 1'b0;
    @(negedge clk);
    chk(!bus_valid && !req_ready, "R1 after reset", {bus_valid, req_ready}, 0);

    for (int n = 0; n < 2; n++) begin
      narrow_mode = n[0];
      for (int i = 0; i < 10; i++) begin
        wait_cfg = i % 2; // R8: odd entries stall every cycle by one clock
        for (int w = 0; w < 2; w++) begin
          logic [19:0] a;
          logic [7:0]  i0, i1;
          a  = addrs[i];
          i0 = a[7:0];
          i1 = 8'(a[7:0] + 8'd1);
          do_req(1'b0, w[0], a, 16'h0, rv);
          ev = w ? {shadow[i1], shadow[i0]} : {8'h00, shadow[i0]};
          chk(rv == ev, w ? "R6 word read little-endian" : "R3 byte read zero-extended", rv, ev);
          wv = {8'(8'h5A ^ a[7:0] ^ 8'(n)), 8'(8'hC3 + a[7:0] + 8'(w))};
          do_req(1'b1, w[0], a, wv, rv);
          chk(mem[i0] == wv[7:0], "R10 low byte stored at address", mem[i0], wv[7:0]);
          shadow[i0] = wv[7:0];
          if (w) begin
            chk(mem[i1] == wv[15:8], "R6 high byte stored at address+1", mem[i1], wv[15:8]);
            shadow[i1] = wv[15:8];
          end else begin
            chk(mem[i1] == shadow[i1], "R10 neighbour byte untouched", mem[i1], shadow[i1]);
          end
          do_req(1'b0, w[0], a, 16'h0, rv);
          ev = w ? {shadow[i1], shadow[i0]} : {8'h00, shadow[i0]};
          chk(rv == ev, "R2 read back after write", rv, ev);
        end
      end
    end
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule